// File: doc/BRIEF.md
# Dual-Channel Power Mode Controller

This block decides the power state of each half of a two-channel converter. It takes a global active-low power-down input and a two-bit sleep selector. For each channel it drives a bias enable for the slow bias circuits, a run enable that powers the channel and gates its internal clock, and a ready flag. It also drives one output-clear signal that holds the converter's digital outputs at zero. The bias cells and the clock gating cells sit outside this block, which only drives their control lines.

Holding power-down low overrides every other input. While it is low, all channel state is discarded and the references are taken as unsettled. A channel that wakes after a power-down therefore waits the long start-up delay. A channel that wakes from sleep, after it has completed a start-up since the last power-down, waits the short delay. Both delays are counted in sample clocks.

After reset the block is uninitialised. It enables nothing until power-down has been seen low at least once, so a power-down cycle must come before the first activation.

Top module: `pmc_dual_power`

## Requirements
- R1: After reset, `out_clr` is 1 and every bit of `bias_on`, `run_en` and `ready` is 0.
- R2: In the cycle after a clock edge that samples `pwr_dn_n` low, `out_clr` is 1 and all bits of `bias_on`, `run_en` and `ready` are 0, whatever `sleep_sel` holds.
- R3: Until `pwr_dn_n` has been sampled low once after reset, no channel is enabled and `out_clr` stays 1, even with `sleep_sel` = 11.
- R4: Sleep selector bit i requests channel i: 00 puts both channels to sleep, 01 runs only channel 0, 10 runs only channel 1, 11 runs both. In the cycle after an edge that samples `pwr_dn_n` high with the block initialised, `out_clr` is 0.
- R5: A sleeping channel of an initialised, powered block has `run_en` 0 and `ready` 0, and keeps `bias_on` at 1. A running channel also has `bias_on` 1.
- R6: A channel that has not completed a start-up since the last power-down raises `ready` exactly PD_DLY cycles (default 1000) after its `run_en` rises. This holds even if the channel spent the time in between asleep.
- R7: A channel that has completed a start-up since the last power-down, and is then slept and woken, raises `ready` exactly SLP_DLY cycles (default 100) after its `run_en` rises.
- R8: Sleeping a channel during its start-up count drops its `run_en` in the next cycle and discards the count. `ready` does not rise, and the next wake-up counts the full delay again.
- R9: `ready` of a channel is never 1 while its `run_en` is 0, and the two channels sequence independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Global power-down, active low, overrides everything |
| sleep_sel | input | NCH (2) | Per-channel run request, bit i for channel i |
| out_clr | output | 1 | Forces the converter's digital outputs to zero |
| bias_on | output | NCH (2) | Slow bias enable per channel |
| run_en | output | NCH (2) | Channel power and internal clock enable |
| ready | output | NCH (2) | Channel start-up complete |

## Verification
A lost initialisation flag shows within one cycle: channels either switch on before any power-down or stay dark after one. A stale "cold" marker shows at the exact cycle `ready` rises, 900 cycles early or late, so each wake-up is checked at the cycle before and the cycle of the expected rise. A counter that is not cleared on an abort shows as an early `ready` on the retried start-up. A power-down that fails to override shows as a live `run_en` in the very next cycle.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
    typedef enum logic [1:0] {
        CH_DOWN  = 2'd0,
        CH_SLEEP = 2'd1,
        CH_WARM  = 2'd2,
        CH_LIVE  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/pmc_init_track.sv
`timescale 1ns/1ps
module pmc_init_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic inited,
    output logic out_clr
);
    typedef struct packed {
        logic seen;
        logic clr;
    } trk_t;

    trk_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.seen = r_q.seen | ~pwr_ok;
        // outputs stay cleared while powered down or before the first power-down
        r_d.clr  = ~pwr_ok | ~r_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.seen <= 1'b0;
            r_q.clr  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign inited  = r_q.seen;
    assign out_clr = r_q.clr;
endmodule

// File: rtl/pmc_chan.sv
`timescale 1ns/1ps
module pmc_chan
    import pmc_pkg::*;
#(
    parameter int PD_DLY  = 1000,
    parameter int SLP_DLY = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic inited,
    input  logic want,
    output logic bias_on,
    output logic run_en,
    output logic ready
);
    localparam int MAXD = (PD_DLY > SLP_DLY) ? PD_DLY : SLP_DLY;
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] PD_LOAD  = CW'(PD_DLY - 1);
    localparam logic [CW-1:0] SLP_LOAD = CW'(SLP_DLY - 1);

    typedef struct packed {
        ch_state_e       state;
        logic [CW-1:0]   cnt;
        logic            cold;
    } ch_t;

    ch_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!pwr_ok) begin
            r_d.state = CH_DOWN;
            r_d.cnt   = '0;
            r_d.cold  = 1'b1;
        end else if (!inited) begin
            r_d.state = CH_DOWN;
            r_d.cnt   = '0;
        end else if (!want) begin
            r_d.state = CH_SLEEP;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                CH_DOWN, CH_SLEEP: begin
                    r_d.state = CH_WARM;
                    r_d.cnt   = r_q.cold ? PD_LOAD : SLP_LOAD;
                end
                CH_WARM: begin
                    if (r_q.cnt == '0) begin
                        r_d.state = CH_LIVE;
                        r_d.cold  = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                default: r_d.state = CH_LIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= CH_DOWN;
            r_q.cnt   <= '0;
            r_q.cold  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bias_on = (r_q.state != CH_DOWN);
    assign run_en  = (r_q.state == CH_WARM) || (r_q.state == CH_LIVE);
    assign ready   = (r_q.state == CH_LIVE);
endmodule

// File: rtl/pmc_dual_power.sv
`timescale 1ns/1ps
module pmc_dual_power #(
    parameter int PD_DLY  = 1000,
    parameter int SLP_DLY = 100,
    parameter int NCH     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_dn_n,
    input  logic [NCH-1:0] sleep_sel,
    output logic           out_clr,
    output logic [NCH-1:0] bias_on,
    output logic [NCH-1:0] run_en,
    output logic [NCH-1:0] ready
);
    logic inited;

    pmc_init_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_ok  (pwr_dn_n),
        .inited  (inited),
        .out_clr (out_clr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pmc_chan #(
            .PD_DLY  (PD_DLY),
            .SLP_DLY (SLP_DLY)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_ok  (pwr_dn_n),
            .inited  (inited),
            .want    (sleep_sel[i]),
            .bias_on (bias_on[i]),
            .run_en  (run_en[i]),
            .ready   (ready[i])
        );
    end
endmodule

// File: rtl/pmc_dual_power_chk.sv
`timescale 1ns/1ps
module pmc_dual_power_chk #(
    parameter int PD_DLY  = 1000,
    parameter int SLP_DLY = 100,
    parameter int NCH     = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwr_dn_n,
    input logic [NCH-1:0] sleep_sel,
    input logic           out_clr,
    input logic [NCH-1:0] bias_on,
    input logic [NCH-1:0] run_en,
    input logic [NCH-1:0] ready
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (!pwr_dn_n) seen_q <= 1'b1;
    end

    assert_pd_override_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> (out_clr && run_en == '0 && ready == '0 && bias_on == '0));

    assert_no_early_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (run_en == '0 && out_clr));

    for (genvar i = 0; i < NCH; i++) begin : g_c
        int unsigned wcnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wcnt <= 0;
            else if (run_en[i] && !ready[i]) wcnt <= wcnt + 1;
            else wcnt <= 0;
        end

        assert_bias_with_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
            run_en[i] |-> bias_on[i]);

        assert_delay_len_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ready[i]) |-> (wcnt == PD_DLY || wcnt == SLP_DLY));

        assert_sleep_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_dn_n && !sleep_sel[i]) |=> (!run_en[i] && !ready[i]));

        assert_ready_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ready[i] |-> run_en[i]);
    end
endmodule

bind pmc_dual_power pmc_dual_power_chk #(
    .PD_DLY  (PD_DLY),
    .SLP_DLY (SLP_DLY),
    .NCH     (NCH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn_n  (pwr_dn_n),
    .sleep_sel (sleep_sel),
    .out_clr   (out_clr),
    .bias_on   (bias_on),
    .run_en    (run_en),
    .ready     (ready)
);

// File: tb/test_pmc_dual_power.sv
`timescale 1ns/1ps
module test_pmc_dual_power;
    localparam int PD  = 1000;
    localparam int SLP = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn_n = 1'b1;
    logic [1:0] sleep_sel = 2'b11;
    logic       out_clr;
    logic [1:0] bias_on, run_en, ready;

    int unsigned cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned at;
        logic [6:0]  vec;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    pmc_dual_power #(.PD_DLY(PD), .SLP_DLY(SLP), .NCH(2)) i_pmc_dual_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn_n  (pwr_dn_n),
        .sleep_sel (sleep_sel),
        .out_clr   (out_clr),
        .bias_on   (bias_on),
        .run_en    (run_en),
        .ready     (ready)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: vec = {out_clr, bias_on[1:0], run_en[1:0], ready[1:0]}
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at == cyc) begin
            exp_t e;
            logic [6:0] act;
            e   = q.pop_front();
            act = {out_clr, bias_on, run_en, ready};
            checks++;
            if (act !== e.vec) begin
                failures++;
                $display("FAIL %s cycle %0d actual=%b expected=%b", e.tag, cyc, act, e.vec);
            end
        end
    end

    task automatic expect_at(input int unsigned off, input logic [6:0] v, input string tag);
        exp_t e;
        e.at = cyc + off;
        e.vec = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_at(1, 7'b1_00_00_00, "R1 reset state");
        step(1);
        expect_at(5, 7'b1_00_00_00, "R3 no enable before power-down");
        step(5);
        pwr_dn_n = 1'b0;
        expect_at(1, 7'b1_00_00_00, "R2 power-down with sleep_sel=11");
        step(3);
        pwr_dn_n = 1'b1;
        sleep_sel = 2'b01;
        expect_at(1, 7'b0_11_01_00, "R4 sel=01 R5 ch1 asleep");
        expect_at(PD, 7'b0_11_01_00, "R6 ch0 still starting");
        expect_at(PD + 1, 7'b0_11_01_01, "R6 ch0 ready after long delay");
        step(PD + 1);
        sleep_sel = 2'b11;
        expect_at(1, 7'b0_11_11_01, "R4 sel=11 R9 ch0 unaffected");
        expect_at(PD, 7'b0_11_11_01, "R6 ch1 still cold");
        expect_at(PD + 1, 7'b0_11_11_11, "R6 ch1 long delay after sleep");
        step(PD + 1);
        sleep_sel = 2'b01;
        expect_at(1, 7'b0_11_01_01, "R5 ch1 sleeps with bias on");
        step(3);
        sleep_sel = 2'b11;
        expect_at(1, 7'b0_11_11_01, "R7 ch1 restart");
        expect_at(SLP, 7'b0_11_11_01, "R7 ch1 not yet ready");
        expect_at(SLP + 1, 7'b0_11_11_11, "R7 short delay");
        step(SLP + 1);
        sleep_sel = 2'b01;
        step(2);
        sleep_sel = 2'b11;
        step(50);
        sleep_sel = 2'b01;
        expect_at(1, 7'b0_11_01_01, "R8 abort drops run");
        step(2);
        sleep_sel = 2'b11;
        expect_at(SLP, 7'b0_11_11_01, "R8 full recount, not ready");
        expect_at(SLP + 1, 7'b0_11_11_11, "R8 ready after full recount");
        step(SLP + 1);
        pwr_dn_n = 1'b0;
        expect_at(1, 7'b1_00_00_00, "R2 power-down overrides active");
        step(2);
        pwr_dn_n = 1'b1;
        sleep_sel = 2'b10;
        expect_at(1, 7'b0_11_10_00, "R4 sel=10");
        expect_at(PD, 7'b0_11_10_00, "R6 ch1 cold again");
        expect_at(PD + 1, 7'b0_11_10_10, "R6 ch1 long delay after power-down");
        step(PD + 1);
        sleep_sel = 2'b00;
        expect_at(1, 7'b0_11_00_00, "R4 sel=00 R5 both asleep");
        step(3);
        if (q.size() != 0) begin
            failures += q.size();
            $display("FAIL R9 %0d expectations unconsumed actual=%0d expected=0", q.size(), q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule